// File: doc/BRIEF.md
# Two-Party Shared Memory Bus Arbiter with Bank Decode

This block sits on one side of an external memory bus that two identical devices share. Each device drives a single ownership line to its peer and reads the peer's line as an incoming request. While the local device holds the bus, a rise on the peer's line makes the block finish whatever memory access is under way. The block then turns off its bus drivers and drops its own line, which hands the bus over. The block keeps the bus parked with itself while nobody else asks for it, so back-to-back local accesses need no handshake.

Before taking the bus back, the block waits a programmable number of clocks counted from the moment it let go. It asks again only when local logic has an access pending. An 8-bit boundary register splits the 16-bit address space into two banks. Bank 0 covers every address whose upper byte is at or below the boundary, and bank 1 covers the rest. The matching active-low bank select is driven only while the block owns the bus and an access is running. The memory timing lies outside the block. It is represented by a request input, a grant output and a busy input that stays high for the whole of an access.

Top module: `shm_arbiter`

## Requirements
- R1: After reset, `own_o` and `bus_oe` are 0, `bank_sel_n` is 2'b11, the boundary register reads 0xFF and the spacing register reads 0x08.
- R2: With `cfg_we` high at a clock edge, `cfg_sel`=0 loads `cfg_wdata[7:0]` into the boundary register and `cfg_sel`=1 loads `cfg_wdata[3:0]` into the spacing register. `cfg_rdata` shows the selected register combinationally, and the spacing register is zero-extended in bits 7:4.
- R3: If the block does not own the bus, the spacing has elapsed and `acc_req` is high at an edge, `own_o` rises at that edge. `bus_oe` rises at the first later edge at which `peer_req` is low, and it stays low while `peer_req` is high.
- R4: Once `bus_oe` is high, the block keeps the bus while `peer_req` stays low, even when `acc_req` is low.
- R5: When the block drives the bus and an edge sees `peer_req` high with `acc_busy` low, `own_o` and `bus_oe` both fall at that edge. `bus_oe` is never high while `own_o` is low.
- R6: While `acc_busy` is high, the block does not release the bus, whatever `peer_req` does.
- R7: `acc_grant` is high exactly when `bus_oe` is high and `peer_req` is low.
- R8: With `acc_req` held high and `peer_req` low after a release, `own_o` stays low for exactly max(W,1) clock cycles. W is the spacing register value at the release edge, so values 0 and 1 both give one cycle.
- R9: While `bus_oe` and `acc_busy` are both high, `bank_sel_n` is 2'b10 (bank 0 active) when `acc_addr[15:8]` <= boundary, and 2'b01 (bank 1 active) otherwise.
- R10: `bank_sel_n` is 2'b11 whenever `bus_oe` or `acc_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 boundary, 1 spacing |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected register, read combinationally |
| acc_req | input | 1 | Local logic has a memory access to perform |
| acc_busy | input | 1 | A memory access is in progress |
| acc_addr | input | 16 | Memory address of the current access |
| acc_grant | output | 1 | An access may start in this cycle |
| peer_req | input | 1 | Ownership line of the peer device |
| own_o | output | 1 | Ownership/request line to the peer device |
| bus_oe | output | 1 | Output enable for the shared bus drivers |
| bank_sel_n | output | 2 | Active-low bank selects, bit 0 for bank 0 |

## Verification
A peer request that arrives in the middle of an access is a key corner case. A design that ignored `acc_busy` would cut the access short and drop `bus_oe` in the middle of a memory cycle. The spacing is measured for values 0, 1, 3, 8 and 15. An off-by-one in the (value - 1) rule, or in the treatment of 0 and 1, would show up as a handover gap one cycle too long or too short. The bench also asks for the bus while the peer still holds it, to catch a design that enables its drivers before the peer has let go. Addresses on either side of each boundary value, including boundaries 0x00 and 0xFF, catch a decoder that uses less-than where it should use less-or-equal, or that selects a bank while it does not own the bus.

// File: rtl/shm_arb_pkg.sv
package shm_arb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_ASK  = 2'd1,
    ARB_HOLD = 2'd2
  } arb_state_e;

  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/shm_cfg_regs.sv
module shm_cfg_regs #(
  parameter int unsigned CFG_W     = 8,
  parameter int unsigned BOUND_W   = 8,
  parameter int unsigned WAIT_W    = 4,
  parameter logic [BOUND_W-1:0] BOUND_RST = '1,
  parameter logic [WAIT_W-1:0]  WAIT_RST  = WAIT_W'(8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               sel,
  input  logic [CFG_W-1:0]   wdata,
  output logic [CFG_W-1:0]   rdata,
  output logic [BOUND_W-1:0] bound_o,
  output logic [WAIT_W-1:0]  wait_o
);

  logic [BOUND_W-1:0] bound_q, bound_d;
  logic [WAIT_W-1:0]  wait_q,  wait_d;
  logic               bound_en, wait_en;

  assign bound_en = wr_en & ~sel;
  assign wait_en  = wr_en &  sel;

  always_comb begin
    bound_d = bound_q;
    wait_d  = wait_q;
    if (bound_en) bound_d = wdata[BOUND_W-1:0];
    if (wait_en)  wait_d  = wdata[WAIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_q <= BOUND_RST;
      wait_q  <= WAIT_RST;
    end else begin
      if (bound_en) bound_q <= bound_d;
      if (wait_en)  wait_q  <= wait_d;
    end
  end

  assign rdata   = sel ? CFG_W'(wait_q) : CFG_W'(bound_q);
  assign bound_o = bound_q;
  assign wait_o  = wait_q;

endmodule

// File: rtl/shm_wait_ctr.sv
module shm_wait_ctr #(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [WAIT_W-1:0] span,
  output logic              done
);

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [WAIT_W-1:0] start_val;
  logic              cnt_en;

  // spacing of 0 or 1 means no extra cycles
  assign start_val = (span > WAIT_W'(1)) ? span - WAIT_W'(1) : '0;
  assign done      = (cnt_q == '0);
  assign cnt_en    = load | (run & ~done);

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = start_val;
    else if (run && !done) cnt_d = cnt_q - WAIT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/shm_arb_fsm.sv
module shm_arb_fsm
  import shm_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic peer_req,
  input  logic acc_req,
  input  logic acc_busy,
  input  logic gap_done,
  output logic own_o,
  output logic drive_o,
  output logic release_o,
  output logic gap_run_o
);

  arb_state_e state_q, state_d;

  assign release_o = (state_q == ARB_HOLD) & peer_req & ~acc_busy;
  assign gap_run_o = (state_q == ARB_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: if (gap_done && acc_req) state_d = ARB_ASK;
      ARB_ASK:  if (!peer_req)           state_d = ARB_HOLD;
      ARB_HOLD: if (release_o)           state_d = ARB_IDLE;
      default:                           state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  assign own_o   = (state_q == ARB_ASK) | (state_q == ARB_HOLD);
  assign drive_o = (state_q == ARB_HOLD);

endmodule

// File: rtl/shm_bank_dec.sv
module shm_bank_dec
  import shm_arb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BOUND_W = 8
) (
  input  logic                 enable,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BOUND_W-1:0]   bound,
  output logic [NUM_BANKS-1:0] sel_n
);

  localparam int unsigned PAGE_LSB = ADDR_W - BOUND_W;

  logic [BOUND_W-1:0] page;
  logic               low_hit;

  assign page    = addr[ADDR_W-1:PAGE_LSB];
  assign low_hit = (page <= bound);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    if (b == 0) begin : g_low
      assign sel_n[b] = ~(enable & low_hit);
    end else begin : g_high
      assign sel_n[b] = ~(enable & ~low_hit);
    end
  end

endmodule

// File: rtl/shm_arbiter.sv
module shm_arbiter
  import shm_arb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned BOUND_W = 8,
  parameter int unsigned WAIT_W  = 4,
  parameter logic [BOUND_W-1:0] BOUND_RST = '1,
  parameter logic [WAIT_W-1:0]  WAIT_RST  = WAIT_W'(8)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  input  logic                 acc_req,
  input  logic                 acc_busy,
  input  logic [ADDR_W-1:0]    acc_addr,
  output logic                 acc_grant,
  input  logic                 peer_req,
  output logic                 own_o,
  output logic                 bus_oe,
  output logic [NUM_BANKS-1:0] bank_sel_n
);

  logic               rst_meta_q, rst_sync_n;
  logic [BOUND_W-1:0] bound_val;
  logic [WAIT_W-1:0]  wait_val;
  logic               gap_done, gap_run, release_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  shm_cfg_regs #(
    .CFG_W(CFG_W), .BOUND_W(BOUND_W), .WAIT_W(WAIT_W),
    .BOUND_RST(BOUND_RST), .WAIT_RST(WAIT_RST)
  ) cfg_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .bound_o(bound_val), .wait_o(wait_val)
  );

  shm_wait_ctr #(.WAIT_W(WAIT_W)) gap_i (
    .clk(clk), .rst_n(rst_sync_n), .load(release_evt), .run(gap_run),
    .span(wait_val), .done(gap_done)
  );

  shm_arb_fsm fsm_i (
    .clk(clk), .rst_n(rst_sync_n), .peer_req(peer_req), .acc_req(acc_req),
    .acc_busy(acc_busy), .gap_done(gap_done), .own_o(own_o), .drive_o(bus_oe),
    .release_o(release_evt), .gap_run_o(gap_run)
  );

  shm_bank_dec #(.ADDR_W(ADDR_W), .BOUND_W(BOUND_W)) dec_i (
    .enable(bus_oe & acc_busy), .addr(acc_addr), .bound(bound_val),
    .sel_n(bank_sel_n)
  );

  assign acc_grant = bus_oe & ~peer_req;

endmodule

// File: rtl/shm_arbiter_chk.sv
module shm_arbiter_chk #(
  parameter int unsigned WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              peer_req,
  input logic              acc_req,
  input logic              acc_busy,
  input logic              acc_grant,
  input logic              own_o,
  input logic              bus_oe,
  input logic [1:0]        bank_sel_n,
  input logic [WAIT_W-1:0] wait_val
);

  logic              own_prev;
  logic [WAIT_W-1:0] wait_prev;
  logic [WAIT_W:0]   low_cnt;
  logic [WAIT_W:0]   need_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_prev  <= 1'b0;
      wait_prev <= '0;
      low_cnt   <= '0;
      need_cnt  <= (WAIT_W+1)'(1);
    end else begin
      own_prev  <= own_o;
      wait_prev <= wait_val;
      if (own_o) low_cnt <= '0;
      else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
      if (own_prev && !own_o)
        need_cnt <= (wait_prev > WAIT_W'(1)) ? (WAIT_W+1)'(wait_prev) : (WAIT_W+1)'(1);
    end
  end

  // R3
  acquire_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_o) |-> $past(acc_req));

  // R3
  drive_after_peer_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> (!$past(peer_req) && own_o));

  // R5
  release_needs_peer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_o) |-> ($past(peer_req) && !$past(acc_busy)));

  // R5
  no_drive_without_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !own_o |-> !bus_oe);

  // R6
  hold_during_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && acc_busy) |=> bus_oe);

  // R7
  grant_only_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant |-> (bus_oe && !peer_req));

  // R8
  handover_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_o) |-> (low_cnt >= need_cnt));

  // R9
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~bank_sel_n) <= 1);

  // R10
  bank_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel_n != 2'b11) |-> (bus_oe && acc_busy));

endmodule

bind shm_arbiter shm_arbiter_chk #(.WAIT_W(WAIT_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .peer_req(peer_req), .acc_req(acc_req),
  .acc_busy(acc_busy), .acc_grant(acc_grant), .own_o(own_o), .bus_oe(bus_oe),
  .bank_sel_n(bank_sel_n), .wait_val(wait_val)
);

// File: tb/shm_arbiter_tb_top.sv
`timescale 1ns/1ps
module shm_arbiter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        acc_req = 1'b0, acc_busy = 1'b0, peer_req = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_grant, own_o, bus_oe;
  logic [1:0]  bank_sel_n;

  int total = 0, bad = 0;
  int m_phase = 0, m_cnt = 0, m_bound = 255, m_wait = 8, m_sync = 0;
  bit started = 0;

  always #5 clk = ~clk;

  shm_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_req(acc_req),
    .acc_busy(acc_busy), .acc_addr(acc_addr), .acc_grant(acc_grant),
    .peer_req(peer_req), .own_o(own_o), .bus_oe(bus_oe), .bank_sel_n(bank_sel_n)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_sync = 0; m_phase = 0; m_cnt = 0; m_bound = 255; m_wait = 8;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      if (m_phase == 0) begin
        if (m_cnt > 0) m_cnt--;
        else if (acc_req) m_phase = 1;
      end else if (m_phase == 1) begin
        if (!peer_req) m_phase = 2;
      end else if (peer_req && !acc_busy) begin
        m_phase = 0;
        m_cnt = (m_wait > 1) ? m_wait - 1 : 0;
      end
      if (cfg_we) begin
        if (cfg_sel) m_wait = cfg_wdata % 16;
        else m_bound = cfg_wdata;
      end
    end
  end

  // compare every cycle, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (started) begin
      int e_own, e_oe, e_bank;
      e_own = (m_phase != 0);
      e_oe  = (m_phase == 2);
      if (e_oe && acc_busy) e_bank = (acc_addr[15:8] <= m_bound) ? 2 : 1;
      else e_bank = 3;
      chk("R3 own_o", own_o, e_own);
      chk("R5 bus_oe", bus_oe, e_oe);
      chk("R7 acc_grant", acc_grant, e_oe && !peer_req);
      chk("R9 R10 bank_sel_n", bank_sel_n, e_bank);
      chk("R2 cfg_rdata", cfg_rdata, cfg_sel ? m_wait : m_bound);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    cyc(1);
    cfg_we = 0;
  endtask

  // release to the peer, then measure how long own_o stays low (R8)
  task automatic gap(int w);
    int n;
    wr(1, 8'(w));
    acc_req = 1; peer_req = 1;
    cyc(1);
    peer_req = 0;
    n = 0;
    #2;
    while (own_o == 0 && n < 40) begin
      n++;
      cyc(1);
      #2;
    end
    chk("R8 gap length", n, (w > 1) ? w : 1);
    cyc(2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(3);
    #2;
    chk("R1 own_o", own_o, 0);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 bank", bank_sel_n, 3);
    chk("R1 boundary", cfg_rdata, 8'hFF);
    cfg_sel = 1; #1;
    chk("R1 spacing", cfg_rdata, 8'h08);
    cyc(1);
    wr(0, 8'h3F);
    wr(1, 8'hA3);
    #2; chk("R2 spacing masked", cfg_rdata, 8'h03);
    cfg_sel = 0; #1; chk("R2 boundary", cfg_rdata, 8'h3F);
    cyc(1);
    // acquire and run accesses around boundary 0x3F
    acc_req = 1; cyc(2);
    acc_busy = 1; acc_addr = 16'h3FFF; cyc(2);
    acc_addr = 16'h4000; cyc(2);
    acc_addr = 16'h0000; cyc(1);
    acc_busy = 0; acc_req = 0;
    cyc(6); #2; chk("R4 parked", bus_oe, 1);
    // peer asks during an access
    cyc(1);
    acc_busy = 1; peer_req = 1; acc_addr = 16'h1234;
    cyc(4); #2; chk("R6 held while busy", bus_oe, 1);
    cyc(1);
    acc_busy = 0; cyc(1); #2;
    chk("R5 released oe", bus_oe, 0);
    chk("R5 released own", own_o, 0);
    // ask while peer still holds the line
    acc_req = 1; acc_busy = 1; cyc(6); #2;
    chk("R3 asking", own_o, 1);
    chk("R3 no drive while peer holds", bus_oe, 0);
    chk("R10 idle bank", bank_sel_n, 3);
    cyc(1);
    acc_busy = 0; peer_req = 0; cyc(1); #2;
    chk("R3 driving", bus_oe, 1);
    cyc(1);
    gap(3); gap(0); gap(1); gap(8); gap(15);
    // boundary extremes
    wr(0, 8'hFF); acc_busy = 1; acc_addr = 16'hFFFF; cyc(1); #2;
    chk("R9 top in bank0", bank_sel_n, 2);
    cyc(1);
    acc_busy = 0; wr(0, 8'h00); acc_busy = 1; acc_addr = 16'h00FF; cyc(1); #2;
    chk("R9 low page", bank_sel_n, 2);
    cyc(1);
    acc_addr = 16'h0100; cyc(1); #2;
    chk("R9 above zero boundary", bank_sel_n, 1);
    cyc(1);
    acc_busy = 0; acc_req = 0; cyc(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule